// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when a differential clock buffer may drive its outputs. It runs on a free-running reference timebase and watches two asynchronous inputs. One is an active-low power-down request. The other is a "clock present" flag from an external activity detector on the buffer's input clock. It grants a single output enable only once the input clock is present, power-down has been released, and a fixed settling interval has elapsed.

The sequencer has four states, exported as a 2-bit code:

| State | Code | Meaning |
|---|---|---|
| OFF | 0 | Powered off |
| WAIT | 1 | Waiting for the input clock and for power-down to be released |
| SETTLE | 2 | Settling delay |
| RUN | 3 | Normal operation |

The named transitions are:

- **T_BOOT** (OFF to WAIT): taken on the first edge after reset.
- **T_ARM** (WAIT to SETTLE): taken when the clock is present and power-down is released.
- **T_DONE** (SETTLE to RUN): taken when the delay expires.
- **T_ABORT** (SETTLE to WAIT): taken on a loss of either condition.
- **T_DROP** (RUN to WAIT): taken on a loss of either condition.

Both asynchronous inputs pass through two-flop synchronizers before the state machine sees them. The delay length is the parameter `SETTLE_CYCLES`, counted in timebase cycles. Its default of 25001 gives just over 0.25 ms at a 100 MHz timebase.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While `rst_i` is high, `state_o` is 0 (OFF) and `out_en_o` is 0.
- R2: On the first rising edge of `clk_i` after `rst_i` falls, the state moves from OFF (0) to WAIT (1), whatever the inputs are.
- R3: In WAIT the block stays in WAIT unless the synchronized `clk_ok_i` is 1 and the synchronized `pd_n_i` is 1 in the same cycle. When both are 1, it takes T_ARM to SETTLE (2).
- R4: Without interruption, the block spends exactly `SETTLE_CYCLES` cycles in SETTLE and then enters RUN (3).
- R5: If either synchronized condition is lost during SETTLE, the next state is WAIT. Every later entry into SETTLE restarts the full `SETTLE_CYCLES` delay.
- R6: In RUN, a 0 on the synchronized `pd_n_i` or on the synchronized `clk_ok_i` moves the block to WAIT on the next edge.
- R7: `out_en_o` is 1 exactly when `state_o` is 3 (RUN). The state codes are OFF=0, WAIT=1, SETTLE=2, RUN=3.
- R8: Each input passes two synchronizer flops. An input change made between edges k and k+1 first affects `state_o` after edge k+3. The synchronizers reset to 0, meaning clock absent and power-down asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference timebase clock |
| rst_i | input | 1 | Asynchronous active-high reset |
| pd_n_i | input | 1 | Power-down request, active low, asynchronous |
| clk_ok_i | input | 1 | Input clock present flag from the activity detector, asynchronous |
| out_en_o | output | 1 | Enable for normal buffer operation |
| state_o | output | 2 | Current state code (0 OFF, 1 WAIT, 2 SETTLE, 3 RUN) |

## Verification
Every input change reaches `state_o` three edges later: two synchronizer stages plus the state register. `out_en_o` follows the state in the same cycle. The bench drives inputs on falling edges. It keeps a cycle model that applies the same three-edge delay and a full-length settle count. It compares the state code and the enable on every falling edge, so each result is sampled half a period after the edge that produced it. Directed checks measure the arm latency and the settle length in cycles. They also sweep a one-cycle drop of each condition over every offset across SETTLE and into RUN.

// File: rtl/clkbuf_pwrup_pkg.sv
package clkbuf_pwrup_pkg;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_WAIT   = 2'd1,
        PS_SETTLE = 2'd2,
        PS_RUN    = 2'd3
    } pwr_state_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/clkbuf_pwrup_sync.sv
module clkbuf_pwrup_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or posedge rst_i) begin
                    if (rst_i) chain_q[g] <= '0;
                    else       chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or posedge rst_i) begin
                    if (rst_i) chain_q[g] <= '0;
                    else       chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkbuf_pwrup_timer.sv
module clkbuf_pwrup_timer #(
    parameter int CYCLES = 25001
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic run_i,
    output logic zero_o
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/clkbuf_pwrup_fsm.sv
module clkbuf_pwrup_fsm
    import clkbuf_pwrup_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ok_s_i,
    input  logic       pdn_s_i,
    input  logic       tmr_zero_i,
    output logic       tmr_load_o,
    output logic       tmr_run_o,
    output logic       en_o,
    output pwr_state_t state_o
);

    pwr_state_t state_q, state_d;
    logic       ready;

    assign ready = ok_s_i & pdn_s_i;

    // state register
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) state_q <= PS_OFF;
        else       state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:    state_d = PS_WAIT;                          // T_BOOT
            PS_WAIT:   if (ready) state_d = PS_SETTLE;             // T_ARM
            PS_SETTLE: begin
                if (!ready)          state_d = PS_WAIT;            // T_ABORT
                else if (tmr_zero_i) state_d = PS_RUN;             // T_DONE
            end
            PS_RUN:    if (!ready) state_d = PS_WAIT;              // T_DROP
        endcase
    end

    // outputs
    always_comb begin
        tmr_load_o = 1'b0;
        tmr_run_o  = 1'b0;
        en_o       = 1'b0;
        unique case (state_q)
            PS_OFF:    ;
            PS_WAIT:   tmr_load_o = ready;
            PS_SETTLE: tmr_run_o  = 1'b1;
            PS_RUN:    en_o       = 1'b1;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/clkbuf_pwrup_seq.sv
module clkbuf_pwrup_seq
    import clkbuf_pwrup_pkg::*;
#(
    parameter int SETTLE_CYCLES = 25001
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       pd_n_i,
    input  logic       clk_ok_i,
    output logic       out_en_o,
    output logic [1:0] state_o
);

    logic [1:0] sync_v;
    logic       ok_sync, pdn_sync;
    logic       tmr_load, tmr_run, tmr_zero;
    pwr_state_t fsm_state;

    clkbuf_pwrup_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i({clk_ok_i, pd_n_i}),
        .sync_o (sync_v)
    );

    assign ok_sync  = sync_v[1];
    assign pdn_sync = sync_v[0];

    clkbuf_pwrup_timer #(
        .CYCLES(SETTLE_CYCLES)
    ) timer_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load_i(tmr_load),
        .run_i (tmr_run),
        .zero_o(tmr_zero)
    );

    clkbuf_pwrup_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ok_s_i    (ok_sync),
        .pdn_s_i   (pdn_sync),
        .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load),
        .tmr_run_o (tmr_run),
        .en_o      (out_en_o),
        .state_o   (fsm_state)
    );

    assign state_o = fsm_state;

endmodule

// File: rtl/clkbuf_pwrup_seq_chk.sv
module clkbuf_pwrup_seq_chk #(
    parameter int SETTLE_CYCLES = 25001
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ok_s,
    input logic       pdn_s,
    input logic       out_en_o,
    input logic [1:0] state_o
);

    logic [31:0] settle_cnt;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)                settle_cnt <= '0;
        else if (state_o == 2'd2) settle_cnt <= settle_cnt + 1;
        else                      settle_cnt <= '0;
    end

    p_reset_off_r1: assert property (@(posedge clk_i)
        rst_i |=> (state_o == 2'd0 && !out_en_o));

    p_boot_wait_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        state_o == 2'd0 |=> state_o == 2'd1);

    p_arm_cond_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd1 && !(ok_s && pdn_s)) |=> state_o == 2'd1);

    p_settle_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(out_en_o) |-> settle_cnt == SETTLE_CYCLES);

    p_settle_abort_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd2 && !(ok_s && pdn_s)) |=> state_o == 2'd1);

    p_run_drop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 2'd3 && !(ok_s && pdn_s)) |=> state_o == 2'd1);

    p_en_in_run_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        out_en_o |-> state_o == 2'd3);

endmodule

bind clkbuf_pwrup_seq clkbuf_pwrup_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ok_s    (ok_sync),
    .pdn_s   (pdn_sync),
    .out_en_o(out_en_o),
    .state_o (state_o)
);

// File: tb/clkbuf_pwrup_seq_tb.sv
module clkbuf_pwrup_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int S          = 6;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_n = 1'b0;
    logic       ok = 1'b0;
    logic       en;
    logic [1:0] st;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkbuf_pwrup_seq #(.SETTLE_CYCLES(S)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .pd_n_i  (pd_n),
        .clk_ok_i(ok),
        .out_en_o(en),
        .state_o (st)
    );

    // Reference model written from the requirements
    logic       m_a1, m_a2, m_b1, m_b2;
    logic [1:0] m_st;
    int         m_left;

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_a1 <= 0; m_a2 <= 0; m_b1 <= 0; m_b2 <= 0;
            m_st <= 2'd0; m_left <= 0;
        end else begin
            m_a1 <= ok;   m_a2 <= m_a1;
            m_b1 <= pd_n; m_b2 <= m_b1;
            case (m_st)
                2'd0: m_st <= 2'd1;
                2'd1: if (m_a2 && m_b2) begin m_st <= 2'd2; m_left <= S; end
                2'd2: begin
                    if (!(m_a2 && m_b2))  m_st <= 2'd1;
                    else if (m_left == 1) m_st <= 2'd3;
                    else                  m_left <= m_left - 1;
                end
                default: if (!(m_a2 && m_b2)) m_st <= 2'd1;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(req_of(m_st), int'(st), int'(m_st));
            chk("R7", int'(en), int'(m_st == 2'd3));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pd_n = 1'b0; ok = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    initial begin
        int lat, len;
        // R1: state during reset
        step(3);
        chk("R1", int'(st), 0);
        chk("R1", int'(en), 0);
        rst = 1'b0;
        step(1);
        chk("R2", int'(st), 1);
        cmp_en = 1'b1;

        // R3: only one condition present keeps WAIT
        ok = 1'b1; step(12);
        chk("R3", int'(st), 1);
        ok = 1'b0; pd_n = 1'b1; step(12);
        chk("R3", int'(st), 1);

        // R8: arm latency of three edges
        ok = 1'b1;
        lat = 0;
        while (st != 2'd2 && lat < 20) begin step(1); lat++; end
        chk("R8", lat, 3);

        // R4: settle length
        len = 0;
        while (st == 2'd2 && len < 4*S) begin step(1); len++; end
        chk("R4", len, S);
        chk("R4", int'(st), 3);
        chk("R7", int'(en), 1);

        // R6: power-down in RUN, seen three edges later
        pd_n = 1'b0; step(2);
        chk("R8", int'(st), 3);
        step(1);
        chk("R6", int'(st), 1);
        chk("R7", int'(en), 0);

        // R5: abort mid-settle, then a full-length settle again
        pd_n = 1'b1; step(3 + S/2);
        chk("R5", int'(st), 2);
        ok = 1'b0; step(1); ok = 1'b1; step(2);
        chk("R5", int'(st), 1);
        while (st != 2'd2) step(1);
        len = 0;
        while (st == 2'd2 && len < 4*S) begin step(1); len++; end
        chk("R5", len, S);

        // Sweep: one-cycle drop of clock, power-down or both at every offset
        for (int sig = 0; sig < 3; sig++) begin
            for (int k = 0; k < S + 5; k++) begin
                do_reset();
                ok = 1'b1; pd_n = 1'b1;
                step(k + 3);
                if (sig != 1) ok = 1'b0;
                if (sig != 0) pd_n = 1'b0;
                step(1);
                ok = 1'b1; pd_n = 1'b1;
                step(3*S + 12);
                chk("R4", int'(st), 3);
            end
        end

        // R1 again: reset asserted from RUN
        @(negedge clk);
        cmp_en = 1'b0;
        rst = 1'b1;
        step(1);
        chk("R1", int'(st), 0);
        chk("R1", int'(en), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule